// File: doc/BRIEF.md
# Four-Lane Framed DDR Serializer

This block turns the parallel 8-bit results of four converter channels into four serial lanes, one lane per channel, for transmission at double data rate. It runs on a single fast clock at eight times the sample rate and sends one bit per fast cycle, most significant bit first. Alongside the lanes it drives a forwarded bit clock that changes level on every bit, so that each lane transfers data on both edges of that clock. It also drives a frame clock at the sample rate whose rising edge marks the first bit of every byte.

An upstream converter presents a four-channel word and a one-cycle sample strobe every eight fast cycles. The block captures the word into a holding register, where it clamps any out-of-range sample and optionally converts it to two's complement. The shift registers reload only at a byte boundary. When the active-low lock input reports that the fast clock is unlocked, every output freezes and the byte in flight is dropped. Transmission resumes only at the next sample strobe, so the frame clock and the lane data stay byte-aligned. Power-down removes output enable and halts the block in the same way.

Top module: `ddrser_top`

## Requirements
- R1: Each lane carries its own channel's byte most significant bit first, one bit per fast-clock cycle, eight bits per byte, and the four lanes are independent of each other.
- R2: While bytes are being sent, the bit clock changes level on every fast cycle. It is high during bit positions 0, 2, 4 and 6 of a byte, counting the MSB as position 0, so that it rises with the MSB.
- R3: The frame clock is high during bit positions 0 to 3 of every byte and low during positions 4 to 7. Its rising edge coincides with the MSB.
- R4: When the format select is 1 at the sample strobe, the MSB of the (possibly clamped) sample is inverted, which turns offset binary into two's complement. When it is 0, the sample is sent unchanged.
- R5: If a channel's overrange bit is set at the strobe, that lane's byte becomes all ones when the raw sample's MSB is 1 and all zeros otherwise; format conversion is applied after this clamp. The overrange flag is high for exactly the bytes in which at least one channel was overrange, and it changes only when a new byte starts.
- R6: A word strobed at clock edge P while the block is idle appears with its MSB on the lanes after edge P+1. While running, the next byte starts right after the eighth bit, taken from the word most recently captured. The strobe is expected every eight cycles.
- R7: At any clock edge where the lock input is high, the lanes, bit clock, frame clock and overrange flag keep their values, and the byte in progress is abandoned.
- R8: After the lock input returns low, the outputs stay unchanged until the next sample strobe. The byte then starts from its MSB one edge after that strobe, with the frame clock rising.
- R9: Power-down high clears output enable at the next edge and halts the lanes as in R7. After power-down is released, output enable returns at the next edge and transmission restarts as in R8.
- R10: A synchronous active-low reset clears lanes, bit clock, frame clock, overrange flag and output enable to 0 and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, eight times the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe: sample word valid |
| smp_data | input | 32 | Four 8-bit offset-binary samples, channel 0 in the low byte |
| smp_ovr | input | 4 | Per-channel overrange bit for the strobed samples |
| twos_sel | input | 1 | 1 selects two's complement output, 0 offset binary |
| lock_n | input | 1 | Active-low clock-lock status; high freezes the outputs |
| pwdn | input | 1 | Power-down request |
| lane_sd | output | 4 | Serial data, one bit per lane |
| bit_clk | output | 1 | Forwarded DDR bit clock |
| frm_clk | output | 1 | Frame clock, high for the first half of each byte |
| ovr_flag | output | 1 | High while a byte with an overrange channel is sent |
| out_en | output | 1 | Output enable, low in power-down |

## Verification
On every cycle, the assertions check that an unlocked edge freezes lanes and clocks, that the bit clock toggles on each running cycle, that each byte start raises both clocks, that the overrange flag moves only at a byte start, that idle lanes stay quiet, and that power-down drops output enable. Only the bench scenarios can show the bit-exact content of each lane: MSB-first order, clamping to the correct rail, MSB inversion under the format select, and alignment of a restarted byte to the strobe. They also show that a byte abandoned on lock loss is never resumed.

// File: rtl/ddrser_pkg.sv
// Shared types for the four-lane framed DDR serializer.
package ddrser_pkg;

    // Transmission state of the frame timer.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

endpackage

// File: rtl/ddrser_capture.sv
// Holding register for one multi-channel sample word.
// On the sample strobe it clamps out-of-range channels to the rail given by
// the raw MSB, applies the output-format select, and stores the word together
// with the OR of the overrange bits. It also provides a one-cycle delayed copy
// of the strobe, which marks "fresh word available" for the frame timer.
// Assumes offset-binary input samples.
module ddrser_capture #(
    parameter int NCH = 4,
    parameter int W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             fmt_twos,
    input  logic [NCH*W-1:0] raw,
    input  logic [NCH-1:0]   ovr_in,
    output logic [NCH*W-1:0] hold_word,
    output logic             hold_ovr,
    output logic             stb_d
);

    logic [NCH*W-1:0] conv;

    // Per-channel clamp, then format conversion by MSB inversion.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [W-1:0] raw_w;
        logic [W-1:0] clamp_w;
        assign raw_w   = raw[ch*W +: W];
        assign clamp_w = ovr_in[ch] ? {W{raw_w[W-1]}} : raw_w;
        assign conv[ch*W +: W] = {clamp_w[W-1] ^ fmt_twos, clamp_w[W-2:0]};
    end

    // Capture the converted word on the strobe and delay the strobe by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_word <= '0;
            hold_ovr  <= 1'b0;
            stb_d     <= 1'b0;
        end else begin
            stb_d <= stb;
            if (stb) begin
                hold_word <= conv;
                hold_ovr  <= |ovr_in;
            end
        end
    end

endmodule

// File: rtl/ddrser_timer.sv
// Byte framing for all lanes.
// Counts bit positions within a byte, decides when the shift registers load,
// and produces the forwarded bit clock and the frame clock. A halt (unlock or
// power-down) freezes both clocks and drops back to idle. From idle, a byte
// starts only on the cycle after a sample strobe.
// Assumes W is even and the strobe period is W cycles.
module ddrser_timer
    import ddrser_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic stb_d,
    output logic load,
    output logic running,
    output logic bit_clk_q,
    output logic frm_clk_q
);

    localparam int BW = $clog2(W);
    localparam logic [BW-1:0] LAST    = BW'(W - 1);
    localparam logic [BW-1:0] HALF_M1 = BW'(W / 2 - 1);

    run_state_t    state;
    logic [BW-1:0] bit_idx;

    assign running = (state == ST_RUN);

    // A byte starts after the last bit, or from idle once a fresh word is held.
    assign load = !halt && ((running && bit_idx == LAST) ||
                            (!running && stb_d));

    // Advance the bit position and both forwarded clocks, or freeze on halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_idx   <= '0;
            bit_clk_q <= 1'b0;
            frm_clk_q <= 1'b0;
        end else if (halt) begin
            state <= ST_IDLE;
        end else if (load) begin
            state     <= ST_RUN;
            bit_idx   <= '0;
            bit_clk_q <= 1'b1;
            frm_clk_q <= 1'b1;
        end else if (running) begin
            bit_idx   <= bit_idx + 1'b1;
            bit_clk_q <= ~bit_clk_q;
            frm_clk_q <= (bit_idx < HALF_M1);
        end
    end

endmodule

// File: rtl/ddrser_lane.sv
// One serial lane: a parallel-load, MSB-first shift register.
// Loads on the frame timer's load pulse and shifts while enabled; otherwise
// holds, so the driven bit stays at its last value.
module ddrser_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift_en,
    input  logic [W-1:0] word,
    output logic         sd
);

    logic [W-1:0] sh;

    assign sd = sh[W-1];

    // Load a new byte or move the next bit into the MSB position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load) begin
            sh <= word;
        end else if (shift_en) begin
            sh <= {sh[W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/ddrser_top.sv
// Four-lane framed DDR serializer, top level.
// Captures strobed sample words, frames them into bytes, and shifts every
// channel out on its own lane with a forwarded bit clock and a frame clock.
// An unlocked clock (lock_n high) or power-down freezes all outputs; power-down
// also clears output enable. Assumes the strobe arrives every W cycles.
module ddrser_top #(
    parameter int NCH = 4,
    parameter int W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_stb,
    input  logic [NCH*W-1:0] smp_data,
    input  logic [NCH-1:0]   smp_ovr,
    input  logic             twos_sel,
    input  logic             lock_n,
    input  logic             pwdn,
    output logic [NCH-1:0]   lane_sd,
    output logic             bit_clk,
    output logic             frm_clk,
    output logic             ovr_flag,
    output logic             out_en
);

    logic             halt;
    logic             load;
    logic             running;
    logic             shift_en;
    logic             stb_d;
    logic             hold_ovr;
    logic [NCH*W-1:0] hold_word;

    assign halt     = lock_n | pwdn;
    assign shift_en = running & ~halt & ~load;

    ddrser_capture #(.NCH(NCH), .W(W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (smp_stb),
        .fmt_twos  (twos_sel),
        .raw       (smp_data),
        .ovr_in    (smp_ovr),
        .hold_word (hold_word),
        .hold_ovr  (hold_ovr),
        .stb_d     (stb_d)
    );

    ddrser_timer #(.W(W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt      (halt),
        .stb_d     (stb_d),
        .load      (load),
        .running   (running),
        .bit_clk_q (bit_clk),
        .frm_clk_q (frm_clk)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
        ddrser_lane #(.W(W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .shift_en (shift_en),
            .word     (hold_word[ch*W +: W]),
            .sd       (lane_sd[ch])
        );
    end

    // Overrange flag follows the byte being sent; output enable tracks power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_flag <= 1'b0;
            out_en   <= 1'b0;
        end else begin
            out_en <= ~pwdn;
            if (load) begin
                ovr_flag <= hold_ovr;
            end
        end
    end

endmodule

// File: rtl/ddrser_chk.sv
// Cycle-level properties of the serializer, bound onto ddrser_top.
module ddrser_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           lock_n,
    input logic           pwdn,
    input logic           load,
    input logic           running,
    input logic [NCH-1:0] lane_sd,
    input logic           bit_clk,
    input logic           frm_clk,
    input logic           ovr_flag,
    input logic           out_en
);

    AST_FREEZE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && lock_n) |=> $stable(lane_sd)); // R7

    AST_FREEZE_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && lock_n) |=> ($stable(bit_clk) && $stable(frm_clk) && $stable(ovr_flag))); // R7

    AST_BITCLK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && running && !lock_n && !pwdn) |=> (bit_clk != $past(bit_clk))); // R2

    AST_FRAME_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && load) |=> (frm_clk && bit_clk)); // R3

    AST_OVR_AT_START_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !load) |=> $stable(ovr_flag)); // R5

    AST_IDLE_LANES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !running && !load) |=> $stable(lane_sd)); // R8

    AST_PWDN_OE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && pwdn) |=> !out_en); // R9

endmodule

bind ddrser_top ddrser_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_n   (lock_n),
    .pwdn     (pwdn),
    .load     (load),
    .running  (running),
    .lane_sd  (lane_sd),
    .bit_clk  (bit_clk),
    .frm_clk  (frm_clk),
    .ovr_flag (ovr_flag),
    .out_en   (out_en)
);

// File: tb/ddrser_top_bench.sv
module ddrser_top_bench;

    localparam int NCH = 4;
    localparam int W   = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             smp_stb = 1'b0;
    logic [NCH*W-1:0] smp_data = '0;
    logic [NCH-1:0]   smp_ovr = '0;
    logic             twos_sel = 1'b0;
    logic             lock_n = 1'b0;
    logic             pwdn = 1'b0;
    logic [NCH-1:0]   lane_sd;
    logic             bit_clk;
    logic             frm_clk;
    logic             ovr_flag;
    logic             out_en;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    ddrser_top #(.NCH(NCH), .W(W)) u_ddrser_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_stb  (smp_stb),
        .smp_data (smp_data),
        .smp_ovr  (smp_ovr),
        .twos_sel (twos_sel),
        .lock_n   (lock_n),
        .pwdn     (pwdn),
        .lane_sd  (lane_sd),
        .bit_clk  (bit_clk),
        .frm_clk  (frm_clk),
        .ovr_flag (ovr_flag),
        .out_en   (out_en)
    );

    // Arithmetic stimulus: raw sample and overrange bit per frame and channel.
    function automatic logic [7:0] raw_of(input int b, input int ch);
        return 8'((b * 37 + ch * 59 + 11) % 256);
    endfunction

    function automatic logic ovr_of(input int b, input int ch);
        return ((b + ch) % 5) == 0;
    endfunction

    // Expected lane byte from the requirements: clamp (R5), then MSB flip (R4).
    function automatic logic [7:0] exp_byte(input int b, input int ch, input logic fm);
        logic [7:0] r;
        r = raw_of(b, ch);
        if (ovr_of(b, ch)) r = {8{r[7]}};
        r[7] = r[7] ^ fm;
        return r;
    endfunction

    function automatic logic exp_ovr(input int b);
        logic any;
        any = 1'b0;
        for (int ch = 0; ch < NCH; ch++) any = any | ovr_of(b, ch);
        return any;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] snap();
        return {25'd0, lane_sd, bit_clk, frm_clk, ovr_flag};
    endfunction

    // Stream n frames starting from idle; strobe every 8 cycles, check every bit.
    task automatic run_frames(input int n, input logic fm, input int base, input string tag);
        for (int c = 0; c <= 8 * n + 1; c++) begin
            @(negedge clk);
            if (c >= 2) begin
                int j;
                int b;
                int k;
                logic [7:0] e;
                j = c - 2;
                b = base + j / 8;
                k = j % 8;
                for (int ch = 0; ch < NCH; ch++) begin
                    e = exp_byte(b, ch, fm);
                    chk((k == 0) ? "R6" : (fm ? "R4" : "R1"), 32'(lane_sd[ch]), 32'(e[7-k]));
                end
                chk((j < 8) ? tag : "R3", 32'(frm_clk), 32'(k < 4));
                chk("R2", 32'(bit_clk), 32'(k % 2 == 0));
                chk("R5", 32'(ovr_flag), 32'(exp_ovr(b)));
            end
            twos_sel = fm;
            if (c % 8 == 0 && c / 8 < n) begin
                smp_stb = 1'b1;
                for (int ch = 0; ch < NCH; ch++) begin
                    smp_data[ch*W +: W] = raw_of(base + c / 8, ch);
                    smp_ovr[ch]         = ovr_of(base + c / 8, ch);
                end
            end else begin
                smp_stb = 1'b0;
            end
        end
    endtask

    // Return to idle through a one-cycle unlock.
    task automatic park();
        @(negedge clk);
        smp_stb = 1'b0;
        lock_n  = 1'b1;
        @(negedge clk);
        lock_n  = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] s;
        // R10: synchronous reset values.
        repeat (3) @(negedge clk);
        chk("R10", 32'(lane_sd), 32'd0);
        chk("R10", 32'(bit_clk), 32'd0);
        chk("R10", 32'(frm_clk), 32'd0);
        chk("R10", 32'(ovr_flag), 32'd0);
        chk("R10", 32'(out_en), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", 32'(lane_sd), 32'd0);

        run_frames(6, 1'b0, 0, "R6");
        park();
        run_frames(6, 1'b1, 20, "R6");

        // R7: freeze mid-byte on lock loss.
        repeat (3) @(negedge clk);
        s = snap();
        lock_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R7", snap(), s);
        end
        // R8: relocked but no strobe yet, still frozen.
        lock_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8", snap(), s);
        end
        run_frames(3, 1'b0, 40, "R8");

        // R9: power-down.
        repeat (2) @(negedge clk);
        s = snap();
        pwdn = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9", 32'(out_en), 32'd0);
            chk("R9", snap(), s);
        end
        pwdn = 1'b0;
        @(negedge clk);
        chk("R9", 32'(out_en), 32'd1);
        chk("R9", snap(), s);
        run_frames(3, 1'b1, 60, "R9");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule